// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer with Refresh Scheduling

This block sits between a synchronous host and an asynchronous, address-multiplexed DRAM with a 4-bit data path. The host raises a request with an 18-bit word address, a direction bit and write data. It holds the request until the block pulses `ack`. The block splits the address into a 9-bit row and a 9-bit column and sends them one after the other over a shared 9-bit address bus. It sequences the row strobe, column strobe, write enable and output enable as active-low signals, and it keeps the row open between accesses. A later request to the same row then costs only a column strobe.

A free-running interval counter marks when the next refresh is due. The period is the retention time divided by the row count. A parameter chooses between the short and the long retention period. A due refresh wins over any waiting host request. It first closes an open page, then runs a column-before-row refresh cycle, which needs no address from the controller. Every delay is a parameter counted in clock cycles. The data bus appears as separate input, output and output-enable signals so that a pad ring can merge them into a common I/O.

Top module: `dram_ctl`

## Requirements
- R1: While `rst_n` is low, `ram_ras_n`, `ram_cas_n`, `ram_we_n` and `ram_oe_n` are all 1, and `dq_oe` and `ack` are both 0.
- R2: When `ram_ras_n` falls while `ram_cas_n` is high, `ram_a` carries `addr[17:9]` (the row). When `ram_cas_n` falls while `ram_ras_n` is low, `ram_a` carries `addr[8:0]` (the column).
- R3: On a read (`wr`=0), `ram_we_n` stays 1 and `dq_oe` stays 0. `ram_oe_n` is 0 while the column strobe is low. `rdata` holds the `dq_in` value sampled T_CAS clocks after `ram_cas_n` falls.
- R4: On a write (`wr`=1), `ram_we_n` is 0 and `dq_oe` is 1, with `dq_out` equal to `wdata`, at least one clock before `ram_cas_n` falls. Both are held until the column strobe ends.
- R5: A request whose row equals the row still open opens no new row. `ram_ras_n` stays low, and only a new column strobe is issued.
- R6: Between any two row openings, `ram_ras_n` stays high for at least T_RP clocks.
- R7: A refresh drops `ram_cas_n` at least one clock before `ram_ras_n` falls, and the row strobe falls while the column strobe is low.
- R8: With the host idle, refreshes start exactly REFI clocks apart. REFI equals (8 ms, or 64 ms when EXT_RET=1) divided by (clock period × 512). At 10 ns this gives 1562 clocks or 12500 clocks.
- R9: A due refresh is served before a waiting host request and closes the open page. Under a continuous stream of same-row requests, refreshes still start no more than REFI+30 clocks apart, and the first access after a refresh opens its row again.
- R10: `ack` is high for exactly one clock per request. `dq_oe` is high only while a write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address, row in the upper 9 bits |
| wdata | input | 4 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 4 | Read data, valid with ack |
| ram_a | output | 9 | Multiplexed DRAM address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| dq_out | output | 4 | Data driven toward the DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 4 | Data returned by the DRAM |

## Verification
The bench targets the following corner cases:
- Page hits and misses at row 0, at row 511 and in column 511. A controller that reopened rows on hits, or kept a stale row on misses, would show extra row openings or lose data at the wrong location.
- A back-to-back stream of same-row requests across several refresh intervals. A design that let the host win would starve refresh indefinitely. A design that forgot to close the page would serve the next access as a hit on a refreshed, closed row.
- Write-enable timing at the column strobe, which catches a late write.
- The exact idle refresh spacing in both retention settings, which catches an off-by-one interval counter or a swapped period.

// File: rtl/dram_ctl_pkg.sv
`timescale 1ns/1ps
package dram_ctl_pkg;

  typedef enum logic [3:0] {
    ST_PRE,   // both strobes high, precharge timer running
    ST_IDLE,  // closed page, waiting
    ST_RSET,  // row address setup, row strobe still high
    ST_ROW,   // row strobe low, row then column on the bus
    ST_CSET,  // column setup inside an open page
    ST_COL,   // column strobe low
    ST_CREC,  // column strobe high recovery
    ST_OPEN,  // page open, waiting
    ST_RCAS,  // refresh: column strobe first
    ST_RRAS   // refresh: both strobes low
  } seq_st_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // clocks between refresh commands for a given retention setting
  function automatic int unsigned refi_cycles(bit ext, int unsigned clk_ns,
                                              int unsigned rows);
    int unsigned ret_ns;
    ret_ns = ext ? 32'd64_000_000 : 32'd8_000_000;
    return ret_ns / (clk_ns * rows);
  endfunction

endpackage

// File: rtl/dram_ctl_refi.sv
`timescale 1ns/1ps
module dram_ctl_refi #(
  parameter int unsigned REFI = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_start,
  output logic ref_tick,
  output logic ref_pend
);
  localparam int CW = $clog2(REFI);

  logic [CW-1:0] cnt;

  assign ref_tick = (cnt == CW'(REFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ref_pend <= 1'b0;
    end else begin
      cnt <= ref_tick ? '0 : cnt + 1'b1;
      if (ref_tick)       ref_pend <= 1'b1;
      else if (ref_start) ref_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_ctl_page.sv
`timescale 1ns/1ps
module dram_ctl_page #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   row_open,
  input  logic                   page_close,
  output logic [ROW_W-1:0]       host_row,
  output logic [COL_W-1:0]       host_col,
  output logic                   page_hit
);
  logic             open_q;
  logic [ROW_W-1:0] open_row;

  assign host_row = addr[ROW_W+COL_W-1:COL_W];
  assign host_col = addr[COL_W-1:0];
  assign page_hit = open_q && (host_row == open_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      open_row <= '0;
    end else if (row_open) begin
      open_q   <= 1'b1;
      open_row <= host_row;
    end else if (page_close) begin
      open_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_ctl_seq.sv
`timescale 1ns/1ps
module dram_ctl_seq
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int DW    = 4,
  parameter int T_RP  = 3,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_CP  = 1,
  parameter int T_CSR = 1,
  parameter int T_RFC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr,
  input  logic [ROW_W-1:0] host_row,
  input  logic [COL_W-1:0] host_col,
  input  logic [DW-1:0]    wdata,
  input  logic             page_hit,
  input  logic             ref_pend,
  input  logic [DW-1:0]    dq_in,
  output logic [ROW_W-1:0] ram_a,
  output logic             ram_ras_n,
  output logic             ram_cas_n,
  output logic             ram_we_n,
  output logic             ram_oe_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             ack,
  output logic [DW-1:0]    rdata,
  output logic             ref_start,
  output logic             row_open,
  output logic             page_close,
  output logic             hit_accept,
  output logic             capture
);
  localparam int unsigned TMAX = max2(max2(max2(T_RP, T_RCD), max2(T_CAS, T_CP)),
                                      max2(T_CSR, T_RFC));
  localparam int CW = $clog2(TMAX + 1);

  seq_st_t          st, nxt;
  logic [CW-1:0]    wcnt, ldv;
  logic             ld, accept, wdone, col_setup;
  logic             lat_wr;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  logic [DW-1:0]    lat_wd;

  assign wdone = (wcnt == '0);

  always_comb begin
    nxt        = st;
    ld         = 1'b0;
    ldv        = '0;
    accept     = 1'b0;
    hit_accept = 1'b0;
    ref_start  = 1'b0;
    capture    = 1'b0;
    unique case (st)
      ST_PRE:  if (wdone) nxt = ST_IDLE;
      ST_IDLE: begin
        if (ref_pend) begin
          nxt = ST_RCAS; ld = 1'b1; ldv = CW'(T_CSR - 1); ref_start = 1'b1;
        end else if (req) begin
          nxt = ST_RSET; accept = 1'b1;
        end
      end
      ST_RSET: begin nxt = ST_ROW; ld = 1'b1; ldv = CW'(T_RCD - 1); end
      ST_ROW:  if (wdone) begin nxt = ST_COL; ld = 1'b1; ldv = CW'(T_CAS - 1); end
      ST_CSET: begin nxt = ST_COL; ld = 1'b1; ldv = CW'(T_CAS - 1); end
      ST_COL:  if (wdone) begin
        capture = 1'b1; nxt = ST_CREC; ld = 1'b1; ldv = CW'(T_CP - 1);
      end
      ST_CREC: if (wdone) nxt = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend) begin
          nxt = ST_PRE; ld = 1'b1; ldv = CW'(T_RP - 1);
        end else if (req) begin
          if (page_hit) begin
            nxt = ST_CSET; accept = 1'b1; hit_accept = 1'b1;
          end else begin
            nxt = ST_PRE; ld = 1'b1; ldv = CW'(T_RP - 1);
          end
        end
      end
      ST_RCAS: if (wdone) begin nxt = ST_RRAS; ld = 1'b1; ldv = CW'(T_RFC - 1); end
      ST_RRAS: if (wdone) begin nxt = ST_PRE;  ld = 1'b1; ldv = CW'(T_RP - 1); end
      default: nxt = ST_PRE;
    endcase
  end

  assign row_open   = accept && (st == ST_IDLE);
  assign page_close = (st == ST_OPEN) && (nxt == ST_PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_PRE;
      wcnt <= CW'(T_RP - 1);
    end else begin
      st   <= nxt;
      wcnt <= ld ? ldv : (wdone ? wcnt : wcnt - 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_wr  <= 1'b0;
      lat_row <= '0;
      lat_col <= '0;
      lat_wd  <= '0;
      ack     <= 1'b0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        lat_wr  <= wr;
        lat_row <= host_row;
        lat_col <= host_col;
        lat_wd  <= wdata;
      end
      ack <= capture;
      if (capture && !lat_wr) rdata <= dq_in;
    end
  end

  // the column goes onto the bus one clock before the column strobe falls
  assign col_setup = ((st == ST_ROW) && wdone) || (st == ST_CSET);

  always_comb begin
    ram_a = lat_row;
    if (col_setup || st == ST_COL || st == ST_CREC || st == ST_OPEN)
      ram_a = ROW_W'(lat_col);
  end

  assign ram_ras_n = !(st == ST_ROW || st == ST_CSET || st == ST_COL ||
                       st == ST_CREC || st == ST_OPEN || st == ST_RRAS);
  assign ram_cas_n = !(st == ST_COL || st == ST_RCAS || st == ST_RRAS);
  assign dq_oe     = lat_wr && (col_setup || st == ST_COL);
  assign ram_we_n  = !dq_oe;
  assign ram_oe_n  = !(!lat_wr && st == ST_COL);
  assign dq_out    = lat_wd;
endmodule

// File: rtl/dram_ctl.sv
`timescale 1ns/1ps
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int DW      = 4,
  parameter int CLK_NS  = 10,
  parameter bit EXT_RET = 1'b0,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_CP    = 1,
  parameter int T_CSR   = 1,
  parameter int T_RFC   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DW-1:0]          wdata,
  output logic                   ack,
  output logic [DW-1:0]          rdata,
  output logic [ROW_W-1:0]       ram_a,
  output logic                   ram_ras_n,
  output logic                   ram_cas_n,
  output logic                   ram_we_n,
  output logic                   ram_oe_n,
  output logic [DW-1:0]          dq_out,
  output logic                   dq_oe,
  input  logic [DW-1:0]          dq_in
);
  localparam int unsigned ROWS = 1 << ROW_W;
  localparam int unsigned REFI = refi_cycles(EXT_RET, CLK_NS, ROWS);

  logic             ref_tick, ref_pend, ref_start;
  logic             row_open, page_close, page_hit, hit_accept, capture;
  logic [ROW_W-1:0] host_row;
  logic [COL_W-1:0] host_col;

  dram_ctl_refi #(.REFI(REFI)) refi_i (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start),
    .ref_tick(ref_tick), .ref_pend(ref_pend)
  );

  dram_ctl_page #(.ROW_W(ROW_W), .COL_W(COL_W)) page_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_open(row_open),
    .page_close(page_close), .host_row(host_row), .host_col(host_col),
    .page_hit(page_hit)
  );

  dram_ctl_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_CSR(T_CSR), .T_RFC(T_RFC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .host_row(host_row),
    .host_col(host_col), .wdata(wdata), .page_hit(page_hit),
    .ref_pend(ref_pend), .dq_in(dq_in), .ram_a(ram_a),
    .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .ack(ack),
    .rdata(rdata), .ref_start(ref_start), .row_open(row_open),
    .page_close(page_close), .hit_accept(hit_accept), .capture(capture)
  );
endmodule

// File: rtl/dram_ctl_sva.sv
`timescale 1ns/1ps
module dram_ctl_sva #(
  parameter int T_RP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ram_ras_n,
  input logic ram_cas_n,
  input logic ram_we_n,
  input logic ram_oe_n,
  input logic dq_oe,
  input logic ack,
  input logic ref_tick,
  input logic ref_pend,
  input logic hit_accept
);
  localparam int HW = $clog2(T_RP + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              hi_cnt <= '0;
    else if (!ram_ras_n)     hi_cnt <= '0;
    else if (hi_cnt < HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (ram_ras_n && ram_cas_n && !dq_oe));

  assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_oe_n && !ram_we_n));

  assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ram_cas_n) && !ram_ras_n && !ram_we_n) |-> ($past(!ram_we_n) && $past(dq_oe)));

  assert_hit_keeps_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> !ram_ras_n);

  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> (hi_cnt >= HW'(T_RP)));

  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ram_ras_n) && !ram_cas_n) |-> $past(!ram_cas_n));

  assert_no_lost_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> !ref_pend);

  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !hit_accept);

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_drive_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ram_we_n && ram_oe_n));
endmodule

bind dram_ctl dram_ctl_sva #(.T_RP(T_RP)) sva_i (
  .clk(clk), .rst_n(rst_n), .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n),
  .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .dq_oe(dq_oe), .ack(ack),
  .ref_tick(ref_tick), .ref_pend(ref_pend), .hit_accept(hit_accept)
);

// File: tb/dram_ctl_tb_top.sv
`timescale 1ns/1ps
module dram_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP       = 3;
  localparam int STD_REFI   = 8_000_000 / (CLK_PERIOD * 512);   // 1562
  localparam int EXT_REFI   = 64_000_000 / (CLK_PERIOD * 512);  // 12500
  localparam int SLACK      = 30;

  // {wr, addr[17:0], data}: data is write data, or expected read data
  localparam logic [22:0] VEC [12] = '{
    {1'b1, 18'h00000, 4'h5}, {1'b1, 18'h00001, 4'hA},
    {1'b1, 18'h3FFFF, 4'hF}, {1'b1, 18'h3FE00, 4'h3},
    {1'b1, 18'h00200, 4'hC}, {1'b0, 18'h00000, 4'h5},
    {1'b0, 18'h00001, 4'hA}, {1'b0, 18'h3FFFF, 4'hF},
    {1'b0, 18'h3FE00, 4'h3}, {1'b0, 18'h00200, 4'hC},
    {1'b1, 18'h00200, 4'h6}, {1'b0, 18'h00200, 4'h6}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [3:0]  wdata = '0, dq_in = '0;
  logic        ack, ram_ras_n, ram_cas_n, ram_we_n, ram_oe_n, dq_oe;
  logic [3:0]  rdata, dq_out;
  logic [8:0]  ram_a;

  logic        x_ack, x_ras_n, x_cas_n, x_we_n, x_oe_n, x_dq_oe;
  logic [3:0]  x_rdata, x_dq_out;
  logic [8:0]  x_a;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .ram_a(ram_a), .ram_ras_n(ram_ras_n),
    .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  dram_ctl #(.EXT_RET(1'b1)) ext_i (
    .clk(clk), .rst_n(rst_n), .req(1'b0), .wr(1'b0), .addr(18'h0),
    .wdata(4'h0), .ack(x_ack), .rdata(x_rdata), .ram_a(x_a),
    .ram_ras_n(x_ras_n), .ram_cas_n(x_cas_n), .ram_we_n(x_we_n),
    .ram_oe_n(x_oe_n), .dq_out(x_dq_out), .dq_oe(x_dq_oe), .dq_in(4'h0)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // behavioural DRAM model and strobe monitor
  logic [3:0] mem [int];
  logic [8:0] last_row = '0, last_col = '0;
  int opens = 0, cbrs = 0, last_cbr_cyc = 0, prev_cbr_cyc = -1;
  int max_gap = 0, min_gap = 1 << 30, hi_cnt = 0;
  bit p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, gap_en = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ram_ras_n) begin
        if (ram_cas_n) begin
          opens++;
          last_row = ram_a;
          chk(hi_cnt >= T_RP, "R6", hi_cnt, T_RP);
        end else begin
          cbrs++;
          chk(!p_cas, "R7", int'(p_cas), 0);
          if (gap_en && prev_cbr_cyc >= 0) begin
            if (cyc - prev_cbr_cyc > max_gap) max_gap = cyc - prev_cbr_cyc;
            if (cyc - prev_cbr_cyc < min_gap) min_gap = cyc - prev_cbr_cyc;
          end
          prev_cbr_cyc = cyc;
          last_cbr_cyc = cyc;
        end
      end
      if (p_cas && !ram_cas_n && !ram_ras_n) begin
        last_col = ram_a;
        if (!ram_we_n) begin
          chk(!p_we && p_dqoe && dq_oe, "R4", int'({p_we, p_dqoe}), 1);
          mem[int'({last_row, ram_a})] = dq_out;
        end else begin
          chk(!ram_oe_n && !dq_oe, "R3", int'({ram_oe_n, dq_oe}), 0);
          dq_in = mem.exists(int'({last_row, ram_a})) ? mem[int'({last_row, ram_a})] : 4'h0;
        end
      end
      if (!ram_cas_n && p_cas && ram_ras_n) chk(!ram_we_n == 1'b0, "R7", int'(ram_we_n), 1);
    end
    hi_cnt = ram_ras_n ? hi_cnt + 1 : 0;
    p_ras = ram_ras_n; p_cas = ram_cas_n; p_we = ram_we_n; p_dqoe = dq_oe;
  end

  // refresh monitor for the long-retention instance
  int x_cbrs = 0, x_first = 0, x_second = 0;
  bit xp_ras = 1'b1;
  always @(negedge clk) begin
    if (rst_n && xp_ras && !x_ras_n && !x_cas_n) begin
      x_cbrs++;
      if (x_cbrs == 1) x_first = cyc;
      if (x_cbrs == 2) x_second = cyc;
    end
    xp_ras = x_ras_n;
  end

  // host page model
  bit pg_open = 1'b0;
  logic [8:0] pg_row = '0;
  int cbr_mark = 0;

  task automatic access(input logic w, input logic [17:0] a, input logic [3:0] d);
    int o0, n, exp_open;
    logic [3:0] got;
    o0 = opens;
    n = 0;
    req = 1'b1; wr = w; addr = a; wdata = d;
    do begin @(negedge clk); n++; end while (!ack && n < 200);
    chk(ack, "R10", int'(ack), 1);
    got = rdata;
    req = 1'b0;
    exp_open = (pg_open && pg_row == a[17:9] && cbrs == cbr_mark) ? 0 : 1;
    chk(opens - o0 == exp_open, "R5", opens - o0, exp_open);
    if (opens - o0 == 1) chk(last_row == a[17:9], "R2", int'(last_row), int'(a[17:9]));
    chk(last_col == a[8:0], "R2", int'(last_col), int'(a[8:0]));
    if (!w) chk(got == d, "R3", int'(got), int'(d));
    pg_open = 1'b1; pg_row = a[17:9]; cbr_mark = cbrs;
    @(negedge clk);
    chk(!ack, "R10", int'(ack), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    int c0, t1, t2;
    repeat (3) @(negedge clk);
    // R1: quiet strobes and bus during reset
    chk(ram_ras_n && ram_cas_n, "R1", int'({ram_ras_n, ram_cas_n}), 3);
    chk(ram_we_n && ram_oe_n, "R1", int'({ram_we_n, ram_oe_n}), 3);
    chk(!dq_oe && !ack, "R1", int'({dq_oe, ack}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++)
      access(VEC[i][22], VEC[i][21:4], VEC[i][3:0]);

    // R9: same-row stream across refreshes; refresh must not starve
    gap_en = 1'b1;
    c0 = cbrs;
    for (int k = 0; k < 1500 && cbrs < c0 + 3; k++) begin
      access(1'b1, {9'h005, 9'(k)}, 4'(k + 1));
      access(1'b0, {9'h005, 9'(k)}, 4'(k + 1));
    end
    gap_en = 1'b0;
    chk(cbrs >= c0 + 3, "R9", cbrs - c0, 3);
    chk(max_gap <= STD_REFI + SLACK, "R9", max_gap, STD_REFI + SLACK);
    chk(min_gap >= STD_REFI - SLACK, "R9", min_gap, STD_REFI - SLACK);

    // R8: exact spacing with the host idle, standard retention
    c0 = cbrs;
    while (cbrs < c0 + 2) @(negedge clk);
    t1 = last_cbr_cyc;
    while (cbrs < c0 + 3) @(negedge clk);
    t2 = last_cbr_cyc;
    chk(t2 - t1 == STD_REFI, "R8", t2 - t1, STD_REFI);

    // R8: long-retention instance
    while (x_cbrs < 2) @(negedge clk);
    chk(x_second - x_first == EXT_REFI, "R8", x_second - x_first, EXT_REFI);

    // page must be closed by refresh: next access reopens the row (R9)
    access(1'b0, {9'h005, 9'h001}, 4'h2);
    finish_up();
  end
endmodule